// File: doc/BRIEF.md
# Transmit Descriptor Ring Manager

This block sits between a host-side table of packet descriptors and a serial transmit engine. The engine works from a circular set of 8-byte descriptors. Each descriptor has a control word and a buffer pointer. The control word carries flag bits in its upper half and a byte length in its lower half. The buffer pointer is fixed for each slot. The block polls the host descriptor at its out position. When that descriptor is marked full and the ring has a free slot, the block requests a buffer copy. When the copy is acknowledged, it hands the slot to the engine by setting the slot's ready flag.

The engine clears the ready flag once it has sent the frame, and it may flag an underrun at the same time. The block then retires slots in ring order. For each retired slot it writes a sent or underrun result back into the matching host descriptor and pulses this port's bit of a doorbell vector. Separate in, out and occupancy counters let the block tell a full ring from an empty one. A port-open pulse rebuilds every control word and clears all counters. That pulse also selects whether every descriptor asks the engine to append a CRC.

Top module: `tx_ring_mgr`

## Requirements
- R1: After reset, all indices are 0 and no copy is pending. Every control word reads 0x18000000, except the last slot, which reads 0x38000000 (bit 29 is wrap). Slot i's pointer word reads BUF_BASE + i*BUF_BYTES.
- R2: A cycle with `open_port` high rebuilds every control word as in R1, aborts any pending copy and clears all indices. If `crc_mode` is 1 in that cycle, bit 26 is also set in every control word.
- R3: The cycle after the block sees all of the following, `copy_req` rises: no copy pending, fewer than DEPTH slots in use, and `host_status` (the host descriptor at `host_rd_idx`) equal to 1 (full). While `copy_req` is high, `copy_src`, `copy_len` and `copy_dst` show the host address, the host length and the pointer of slot `host_rd_idx`.
- R4: A cycle with `copy_req` and `copy_done` both high does three things at the next edge. It sets bit 31 (ready) of the slot at the out index, clears that slot's bit 17 and loads `host_len` into bits 15:0. It advances the out index modulo DEPTH. It adds one to the occupancy. When the occupancy is DEPTH, no copy starts.
- R5: An `eng_done` pulse for a slot whose ready bit is set clears that bit and copies `eng_underrun` into bit 17. For a slot whose ready bit is clear, the pulse has no effect.
- R6: In any cycle where the occupancy is non-zero and the slot at the in index has its ready bit clear, the block retires that slot. In that same cycle `host_wr_en` is high, `host_wr_idx` equals the in index, and `doorbell[PORT_SEL]` is the only doorbell bit that is high. The in index then advances modulo DEPTH and the occupancy drops by one. Nothing is retired at occupancy 0.
- R7: The retirement writes status 3 (underrun) if bit 17 of the retired slot is set, and status 2 (sent) otherwise.
- R8: If a copy completes in the same cycle as a retirement, the occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| open_port | input | 1 | Rebuild ring and clear indices |
| crc_mode | input | 1 | Request CRC flag in every slot on open |
| host_rd_idx | output | IW | Host descriptor being polled (out index) |
| host_status | input | ST_W | Status of host descriptor at host_rd_idx |
| host_addr | input | 32 | Buffer address of host descriptor at host_rd_idx |
| host_len | input | 16 | Length of host descriptor at host_rd_idx |
| host_wr_en | output | 1 | Write a result into a host descriptor |
| host_wr_idx | output | IW | Host descriptor to write (in index) |
| host_wr_status | output | ST_W | Result code: 2 sent, 3 underrun |
| copy_req | output | 1 | Buffer copy requested |
| copy_src | output | 32 | Copy source address |
| copy_dst | output | 32 | Copy destination (slot buffer) |
| copy_len | output | 16 | Copy length in bytes |
| copy_done | input | 1 | Copy finished |
| eng_rd_idx | input | IW | Slot the engine reads |
| eng_word0 | output | 32 | Control word of slot eng_rd_idx |
| eng_word1 | output | 32 | Buffer pointer of slot eng_rd_idx |
| eng_done | input | 1 | Engine finished a slot |
| eng_done_idx | input | IW | Slot the engine finished |
| eng_underrun | input | 1 | Finished slot ran short of data |
| doorbell | output | PORTS | One-cycle transmit-freed pulse toward the host |

## Verification
The hardest case to reach is a retirement in the very cycle a copy is acknowledged. The engine's release must land exactly as the copy handshake closes, and this is the only case that exercises R8. A second hard case is a full ring while the host still offers a packet at the out position. The stimulus reaches both cases in two ways. A directed phase stalls the engine until all DEPTH slots are in use. A long pseudo-random phase varies the copy latency, releases slots at irregular intervals, refills host descriptors and injects releases for slots that are not ready. A behavioural model is compared with every output on every clock throughout.

// File: rtl/tx_ring_mgr.sv
module tx_ring_mgr #(
  parameter int          DEPTH       = 8,
  parameter int          PORTS       = 4,
  parameter int          PORT_SEL    = 0,
  parameter logic [31:0] BUF_BASE    = 32'h0002_0000,
  parameter int          BUF_BYTES   = 1600,
  parameter int          ST_W        = 8,
  parameter int          ST_FULL     = 1,
  parameter int          ST_SENT     = 2,
  parameter int          ST_UNDERRUN = 3,
  localparam int         IW          = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int         CW          = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_port,
  input  logic             crc_mode,
  output logic [IW-1:0]    host_rd_idx,
  input  logic [ST_W-1:0]  host_status,
  input  logic [31:0]      host_addr,
  input  logic [15:0]      host_len,
  output logic             host_wr_en,
  output logic [IW-1:0]    host_wr_idx,
  output logic [ST_W-1:0]  host_wr_status,
  output logic             copy_req,
  output logic [31:0]      copy_src,
  output logic [31:0]      copy_dst,
  output logic [15:0]      copy_len,
  input  logic             copy_done,
  input  logic [IW-1:0]    eng_rd_idx,
  output logic [31:0]      eng_word0,
  output logic [31:0]      eng_word1,
  input  logic             eng_done,
  input  logic [IW-1:0]    eng_done_idx,
  input  logic             eng_underrun,
  output logic [PORTS-1:0] doorbell
);

  localparam int B_RDY  = 31;
  localparam int B_WRAP = 29;
  localparam int B_CRC  = 26;
  localparam int B_UR   = 17;
  localparam logic [31:0] BASE_FLAGS = 32'h1800_0000;

  logic [31:0]   ring [DEPTH];
  logic [IW-1:0] out_idx, in_idx;
  logic [CW-1:0] cnt;
  logic          busy;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] i);
    return (i == IW'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  function automatic logic [31:0] fresh(input int i, input logic crc);
    logic [31:0] w;
    w         = BASE_FLAGS;
    w[B_WRAP] = (i == DEPTH - 1);
    w[B_CRC]  = crc;
    return w;
  endfunction

  function automatic logic [31:0] bufptr(input logic [IW-1:0] i);
    return BUF_BASE + 32'(i) * 32'(BUF_BYTES);
  endfunction

  wire retire = (cnt != '0) && !ring[in_idx][B_RDY];
  wire start  = !busy && (cnt < CW'(DEPTH)) && (host_status == ST_W'(ST_FULL));
  wire finish = busy && copy_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_idx <= '0;
      in_idx  <= '0;
      cnt     <= '0;
      busy    <= 1'b0;
      for (int i = 0; i < DEPTH; i++) ring[i] <= fresh(i, 1'b0);
    end else if (open_port) begin
      out_idx <= '0;
      in_idx  <= '0;
      cnt     <= '0;
      busy    <= 1'b0;
      for (int i = 0; i < DEPTH; i++) ring[i] <= fresh(i, crc_mode);
    end else begin
      if (eng_done && ring[eng_done_idx][B_RDY]) begin
        ring[eng_done_idx][B_RDY] <= 1'b0;
        ring[eng_done_idx][B_UR]  <= eng_underrun;
      end
      if (finish) begin
        ring[out_idx][B_RDY]  <= 1'b1;
        ring[out_idx][B_UR]   <= 1'b0;
        ring[out_idx][15:0]   <= host_len;
        out_idx               <= nxt(out_idx);
      end
      if (retire) in_idx <= nxt(in_idx);
      cnt <= cnt + CW'(finish) - CW'(retire);
      if (start)       busy <= 1'b1;
      else if (finish) busy <= 1'b0;
    end
  end

  assign host_rd_idx    = out_idx;
  assign copy_req       = busy;
  assign copy_src       = host_addr;
  assign copy_len       = host_len;
  assign copy_dst       = bufptr(out_idx);
  assign eng_word0      = ring[eng_rd_idx];
  assign eng_word1      = bufptr(eng_rd_idx);
  assign host_wr_en     = retire;
  assign host_wr_idx    = in_idx;
  assign host_wr_status = ring[in_idx][B_UR] ? ST_W'(ST_UNDERRUN) : ST_W'(ST_SENT);
  assign doorbell       = retire ? (PORTS'(1) << PORT_SEL) : '0;

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R4
  AST_NO_START_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !open_port && cnt == CW'(DEPTH)) |=> !busy); // R4
  AST_QUEUE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_req && copy_done && !open_port) |=>
      (ring[$past(out_idx)][B_RDY] && host_rd_idx == nxt($past(host_rd_idx)))); // R4
  AST_RETIRE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && !open_port) |=> host_wr_idx == nxt($past(host_wr_idx))); // R6
  AST_SIMUL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && retire && !open_port) |=> cnt == $past(cnt)); // R8
  AST_OPEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    open_port |=> (cnt == '0 && !copy_req && host_rd_idx == '0)); // R2

endmodule

// File: tb/tb_tx_ring_mgr.sv
module tb_tx_ring_mgr;
  localparam int          CLK_P     = 10;
  localparam int          DEPTH     = 8;
  localparam int          PORTS     = 4;
  localparam int          PORT_SEL  = 2;
  localparam logic [31:0] BUF_BASE  = 32'h0002_0000;
  localparam int          BUF_BYTES = 1600;
  localparam int          IW        = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic open_port = 1'b0, crc_mode = 1'b0;
  logic [IW-1:0] host_rd_idx, host_wr_idx, eng_rd_idx = '0, eng_done_idx = '0;
  logic [7:0] host_status, host_wr_status;
  logic [31:0] host_addr, copy_src, copy_dst, eng_word0, eng_word1;
  logic [15:0] host_len, copy_len;
  logic host_wr_en, copy_req, copy_done = 1'b0;
  logic eng_done = 1'b0, eng_underrun = 1'b0;
  logic [PORTS-1:0] doorbell;

  int hm_st [DEPTH];
  int hm_len [DEPTH];
  int hm_addr [DEPTH];
  logic fill_en = 1'b0;
  int fill_idx = 0, fill_len = 0, fill_addr = 0;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int copy_lat = 1, lat_cnt = 0, eng_ptr = 0;

  bit m_busy, m_crc;
  int m_out, m_in, m_cnt;
  bit m_rdy [DEPTH];
  bit m_ur [DEPTH];
  int m_len [DEPTH];

  always #(CLK_P/2) clk = ~clk;

  tx_ring_mgr #(.DEPTH(DEPTH), .PORTS(PORTS), .PORT_SEL(PORT_SEL),
                .BUF_BASE(BUF_BASE), .BUF_BYTES(BUF_BYTES)) dut (
    .clk(clk), .rst_n(rst_n), .open_port(open_port), .crc_mode(crc_mode),
    .host_rd_idx(host_rd_idx), .host_status(host_status), .host_addr(host_addr),
    .host_len(host_len), .host_wr_en(host_wr_en), .host_wr_idx(host_wr_idx),
    .host_wr_status(host_wr_status), .copy_req(copy_req), .copy_src(copy_src),
    .copy_dst(copy_dst), .copy_len(copy_len), .copy_done(copy_done),
    .eng_rd_idx(eng_rd_idx), .eng_word0(eng_word0), .eng_word1(eng_word1),
    .eng_done(eng_done), .eng_done_idx(eng_done_idx), .eng_underrun(eng_underrun),
    .doorbell(doorbell));

  assign host_status = 8'(hm_st[host_rd_idx]);
  assign host_len    = 16'(hm_len[host_rd_idx]);
  assign host_addr   = 32'(hm_addr[host_rd_idx]);

  initial for (int i = 0; i < DEPTH; i++) begin hm_st[i] = 0; hm_len[i] = 0; hm_addr[i] = 0; end

  always @(posedge clk) begin
    if (fill_en) begin
      hm_st[fill_idx]   <= 1;
      hm_len[fill_idx]  <= fill_len;
      hm_addr[fill_idx] <= fill_addr;
    end
    if (host_wr_en) hm_st[host_wr_idx] <= int'(host_wr_status);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_init(input bit crc);
    m_busy = 0; m_crc = crc; m_out = 0; m_in = 0; m_cnt = 0;
    for (int i = 0; i < DEPTH; i++) begin m_rdy[i] = 0; m_ur[i] = 0; m_len[i] = 0; end
  endtask

  always @(negedge clk) begin
    bit e_ret, fin, st;
    logic [31:0] w;
    int ri;
    if (!rst_n) model_init(1'b0);
    e_ret = (m_cnt > 0) && !m_rdy[m_in];
    chk("R4 host_rd_idx", 32'(host_rd_idx), 32'(m_out));
    chk("R3 R8 copy_req", 32'(copy_req), 32'(m_busy));
    chk("R3 copy_dst", copy_dst, BUF_BASE + 32'(m_out) * 32'(BUF_BYTES));
    chk("R3 copy_len", 32'(copy_len), 32'(hm_len[m_out] & 16'hFFFF));
    chk("R3 copy_src", copy_src, 32'(hm_addr[m_out]));
    chk("R6 host_wr_en", 32'(host_wr_en), 32'(e_ret));
    chk("R6 host_wr_idx", 32'(host_wr_idx), 32'(m_in));
    if (e_ret) chk("R7 host_wr_status", 32'(host_wr_status), m_ur[m_in] ? 32'd3 : 32'd2);
    chk("R6 doorbell", 32'(doorbell), e_ret ? (32'd1 << PORT_SEL) : 32'd0);
    ri = int'(eng_rd_idx);
    w = 32'h1800_0000 | (32'(m_rdy[ri]) << 31) | (32'(ri == DEPTH-1) << 29) |
        (32'(m_crc) << 26) | (32'(m_ur[ri]) << 17) | 32'(m_len[ri] & 16'hFFFF);
    chk("R1 R2 R4 R5 eng_word0", eng_word0, w);
    chk("R1 eng_word1", eng_word1, BUF_BASE + 32'(ri) * 32'(BUF_BYTES));
    if (rst_n) begin
      if (open_port) model_init(crc_mode);
      else begin
        fin = m_busy && copy_done;
        st  = !m_busy && (m_cnt < DEPTH) && (host_status == 8'd1);
        if (eng_done && m_rdy[eng_done_idx]) begin
          m_rdy[eng_done_idx] = 0;
          m_ur[eng_done_idx]  = eng_underrun;
        end
        if (fin) begin
          m_rdy[m_out] = 1; m_ur[m_out] = 0; m_len[m_out] = int'(host_len);
          m_out = (m_out + 1) % DEPTH;
        end
        if (e_ret) m_in = (m_in + 1) % DEPTH;
        m_cnt = m_cnt + int'(fin) - int'(e_ret);
        if (st) m_busy = 1; else if (fin) m_busy = 0;
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
    cyc++;
    eng_done = 0; open_port = 0; fill_en = 0;
    eng_rd_idx = IW'(cyc % DEPTH);
    if (copy_req) begin
      if (lat_cnt >= copy_lat) begin copy_done = 1; lat_cnt = 0; end
      else begin copy_done = 0; lat_cnt++; end
    end else begin
      copy_done = 0; lat_cnt = 0;
    end
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic fill(input int idx, input int len, input int addr);
    step();
    fill_en = 1; fill_idx = idx; fill_len = len; fill_addr = addr;
  endtask

  task automatic eng_fin(input int idx, input bit ur);
    step();
    eng_done = 1; eng_done_idx = IW'(idx); eng_underrun = ur;
  endtask

  task automatic do_open(input bit crc);
    step();
    open_port = 1; crc_mode = crc; eng_ptr = 0;
  endtask

  task automatic random_phase(input int n);
    for (int k = 0; k < n; k++) begin
      int r, s;
      step();
      if (cyc % 16 == 0) copy_lat = $urandom % 4;
      r = $urandom % 8;
      if (r < 3 && m_rdy[eng_ptr]) begin
        eng_done = 1; eng_done_idx = IW'(eng_ptr); eng_underrun = ($urandom % 4 == 0);
        eng_ptr = (eng_ptr + 1) % DEPTH;
      end else if (r == 3) begin
        s = $urandom % DEPTH;
        if (!m_rdy[s]) begin eng_done = 1; eng_done_idx = IW'(s); eng_underrun = 1; end
      end
      if ($urandom % 3 == 0) begin
        s = $urandom % DEPTH;
        if (hm_st[s] != 1) begin
          fill_en = 1; fill_idx = s; fill_len = 64 + ($urandom % 1400);
          fill_addr = 32'h4000_0000 + s * 32'h800 + cyc;
        end
      end
    end
  endtask

  initial begin
    run(3);
    rst_n = 1;
    run(4);                               // R1 reset state, idle with empty host table
    copy_lat = 1;
    for (int k = 0; k < 3; k++) fill(k, 100 + k, 32'hA000 + k * 32'h100);  // R3 R4
    run(15);
    eng_fin(0, 0);                        // R5 R6 R7 sent
    eng_fin(1, 1);                        // R7 underrun
    run(5);
    eng_fin(5, 1);                        // R5 release of a slot that is not ready
    run(3);
    for (int k = 3; k < DEPTH; k++) fill(k, 200 + k, 32'hB000 + k * 32'h100);
    fill(0, 300, 32'hC000);
    fill(1, 301, 32'hC100);
    run(30);                              // R4 ring full, host slot 2 still full
    eng_fin(2, 0);
    run(10);
    eng_ptr = 3;
    for (int k = 0; k < 6; k++) begin eng_fin(eng_ptr, k == 2); eng_ptr = (eng_ptr + 1) % DEPTH; end
    run(10);
    do_open(1);                           // R2 crc flag on
    run(3);
    random_phase(2500);                   // R8 coincident copy and retire
    do_open(0);                           // R2 crc flag off
    run(3);
    random_phase(1500);
    run(5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule